// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Idle-Line Detection

This block is the receive side of an asynchronous serial port. It watches a serial line that is sampled sixteen times per bit time and rebuilds each character from it. A character is a low start bit, then 8, 9 or 10 data bits sent least significant bit first, then an optional parity bit, then one high stop bit. Each received character is delivered on a parallel output with a one-cycle valid strobe and a parity error flag.

Alongside framing, the block watches for an idle line: a run of high bit-times as long as one whole character. Configuration decides whether that run may begin inside a character, straight after its start bit, or only once the stop bit has passed. The second choice stops a character whose data ends in ones from being taken for idle.

The receiver can be put to sleep. While it sleeps it delivers no characters. It wakes in one of two ways, chosen by configuration. In idle-line wakeup it wakes when it sees a full character time of ones. In address-mark wakeup it wakes on a character whose top data bit is set, and that character is delivered.

Top module: `uart_idle_rx`

## Requirements
- R1: A character is a start bit (0), then the data bits least significant first, then the parity bit when parity is on, then one stop bit. There are 10 data bits when `ten_bit`=1, whatever `nine_bit` is. There are 9 when only `nine_bit`=1, and 8 otherwise. `rx_data` holds the data right-aligned with unused upper bits at 0, and `rx_valid` pulses for exactly one cycle per delivered character. After reset `rx_valid`, `idle_pulse` and `asleep` are 0.
- R2: Each bit is decided by a majority of the three samples taken 7, 8 and 9 ticks after the falling edge that began the character, plus whole multiples of 16 ticks. A one-tick glitch is therefore outvoted. A start bit whose vote is 1 is dropped as noise and gives no character.
- R3: With `par_en`=1 the parity bit sits just before the stop bit. `par_odd`=0 expects a parity bit equal to the XOR of the data bits. `par_odd`=1 expects its inverse. `par_err` is 1 on a mismatch. With `par_en`=0, `par_err` is 0.
- R4: With `idle_after_stop`=0, every 1-valued bit after the start bit counts toward idle: data, parity, stop and each later 16-tick high period. Any 0-valued bit resets the count.
- R5: With `idle_after_stop`=1, only the high bit-times after a stop bit count. The count restarts at each stop bit, so ones inside a character never count.
- R6: Idle is recognised when the count reaches L = 2 + data bits + parity bit: 10 for 8 data bits without parity, 11 for 8 with parity or 9 without, 12 for 10 without parity.
- R7: `idle_pulse` is a one-cycle pulse. It fires at most once per idle period, only when a character has been delivered since the previous idle, and never while the receiver is asleep.
- R8: A one-cycle `sleep_req` sets `asleep` on the next cycle. While asleep, no character is delivered unless it wakes the receiver.
- R9: With `wake_addr`=0 while asleep, `idle_after_stop` is ignored, so ones inside the character count. `asleep` clears when L ones have been counted, and nothing is delivered by that wakeup.
- R10: With `wake_addr`=1 while asleep, a character whose most significant data bit is 1 clears `asleep` and is delivered. A character with that bit at 0 is discarded, and an idle line does not wake the receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Oversampling enable, 16 per bit time |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| wake_addr | input | 1 | Wakeup method: 0 idle line, 1 address mark |
| idle_after_stop | input | 1 | Idle count start: 0 after start bit, 1 after stop bit |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Parity type: 0 even, 1 odd |
| nine_bit | input | 1 | Nine data bits |
| ten_bit | input | 1 | Ten data bits (wins over nine_bit) |
| sleep_req | input | 1 | Pulse that puts the receiver to sleep |
| rx_data | output | 10 | Received data, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| par_err | output | 1 | Parity mismatch for the delivered character |
| idle_pulse | output | 1 | One-cycle idle-line indication |
| asleep | output | 1 | Receiver is asleep |

## Verification
The hardest case is an all-ones character, which tells the two idle-count modes apart. If the count started too early, the idle pulse would come roughly one character time sooner when counting should wait for the stop bit. If the count started too late, the pulse would come that much later in the other mode. The bench measures the pulse delay for three frame formats, so a wrong character-length formula shows up as a 16-tick step. It also covers:
- a glitch on the start bit and another in the middle of a data bit, where a single-sample decision would produce or corrupt a character;
- a second idle period, and idle before any traffic, where a missing arm flag would pulse again;
- sleeping under each wakeup method, where waking on the wrong event, or delivering the discarded character, shows at the ports.

// File: rtl/uart_idle_pkg.sv
// Shared types for the serial receiver with idle detection.
package uart_idle_pkg;

    // Class of a bit-time event passed from the framer to the idle counter.
    typedef enum logic [1:0] {
        EV_START = 2'd0,   // accepted start bit (always 0)
        EV_BODY  = 2'd1,   // data or parity bit
        EV_STOP  = 2'd2,   // stop bit
        EV_HUNT  = 2'd3    // one full high bit-time between characters
    } ev_kind_t;

    // Framer state.
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_START = 2'd1,
        ST_BODY  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_t;

endpackage

// File: rtl/rx_line_voter.sv
// Synchronises the serial line and forms a three-sample majority.
// Assumes: SYNC_STAGES >= 2; vote covers the current tick and the two before.
module rx_line_voter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_in,
    output logic line_s,
    output logic vote
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [1:0]             hist_q;

    // Metastability chain, idle-high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
    end

    assign line_s = sync_q[SYNC_STAGES-1];

    // Keep the two previous tick samples for the vote.
    always_ff @(posedge clk) begin
        if (!rst_n)    hist_q <= 2'b11;
        else if (tick) hist_q <= {hist_q[0], line_s};
    end

    assign vote = (line_s & hist_q[0]) | (line_s & hist_q[1]) | (hist_q[0] & hist_q[1]);
endmodule

// File: rtl/rx_framer.sv
// Character framer: finds start edges, decides every bit at mid-bit and
// emits one event per bit-time, including high bit-times between characters.
// Assumes: tick is the oversampling enable, OVERSAMPLE ticks per bit.
module rx_framer
    import uart_idle_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_W     = 10,
    parameter int IDX_W      = $clog2(DATA_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_s,
    input  logic              vote,
    input  logic [IDX_W-1:0]  n_data,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              ev_valid,
    output logic              ev_val,
    output ev_kind_t          ev_kind,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              par_err
);
    localparam int             PH_W    = $clog2(OVERSAMPLE);
    localparam logic [PH_W-1:0] MID_PH  = PH_W'(OVERSAMPLE / 2 + 1);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(OVERSAMPLE - 1);

    rx_state_t        state;
    logic [PH_W-1:0]  phase;
    logic [PH_W-1:0]  hunt_cnt;
    logic [IDX_W-1:0] bit_idx;
    logic             par_q;
    logic [IDX_W-1:0] body_last;

    assign body_last = n_data + IDX_W'(par_en) - IDX_W'(1);

    // Frame sequencing, bit decisions and event generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HUNT;
            phase    <= '0;
            hunt_cnt <= '0;
            bit_idx  <= '0;
            par_q    <= 1'b0;
            data     <= '0;
            par_err  <= 1'b0;
            ev_valid <= 1'b0;
            ev_val   <= 1'b0;
            ev_kind  <= EV_HUNT;
            done     <= 1'b0;
        end else begin
            ev_valid <= 1'b0;
            done     <= 1'b0;
            if (tick) begin
                if (state == ST_HUNT) begin
                    if (!line_s) begin
                        state    <= ST_START;
                        phase    <= PH_W'(1);
                        hunt_cnt <= '0;
                    end else if (hunt_cnt == LAST_PH) begin
                        hunt_cnt <= '0;
                        ev_valid <= 1'b1;
                        ev_val   <= 1'b1;
                        ev_kind  <= EV_HUNT;
                    end else begin
                        hunt_cnt <= hunt_cnt + PH_W'(1);
                    end
                end else begin
                    phase <= (phase == LAST_PH) ? '0 : phase + PH_W'(1);
                    if (phase == MID_PH) begin
                        case (state)
                            ST_START: begin
                                if (vote) begin
                                    state    <= ST_HUNT;
                                    hunt_cnt <= '0;
                                end else begin
                                    state    <= ST_BODY;
                                    bit_idx  <= '0;
                                    data     <= '0;
                                    ev_valid <= 1'b1;
                                    ev_val   <= 1'b0;
                                    ev_kind  <= EV_START;
                                end
                            end
                            ST_BODY: begin
                                if (bit_idx < n_data)
                                    data <= data | (DATA_W'(vote) << bit_idx);
                                else
                                    par_q <= vote;
                                ev_valid <= 1'b1;
                                ev_val   <= vote;
                                ev_kind  <= EV_BODY;
                                if (bit_idx == body_last) state <= ST_STOP;
                                else                      bit_idx <= bit_idx + IDX_W'(1);
                            end
                            default: begin
                                state    <= ST_HUNT;
                                hunt_cnt <= '0;
                                done     <= 1'b1;
                                par_err  <= par_en & (par_q ^ (^data) ^ par_odd);
                                ev_valid <= 1'b1;
                                ev_val   <= vote;
                                ev_kind  <= EV_STOP;
                            end
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rx_idle_count.sv
// Counts consecutive high bit-times toward an idle character and flags the
// bit-time on which the count reaches the required length.
// Assumes: need >= 1 and stable while counting.
module rx_idle_count
    import uart_idle_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ev_valid,
    input  logic             ev_val,
    input  ev_kind_t         ev_kind,
    input  logic             after_stop,
    input  logic [CNT_W-1:0] need,
    output logic             hit
);
    logic [CNT_W-1:0] cnt;
    logic             inc;
    logic             zero;

    // Classify the event as count, restart or no effect.
    always_comb begin
        inc  = 1'b0;
        zero = 1'b0;
        if (ev_valid) begin
            case (ev_kind)
                EV_HUNT:  inc  = 1'b1;
                EV_START: zero = 1'b1;
                EV_STOP:  if (after_stop) zero = 1'b1;
                          else if (ev_val) inc = 1'b1;
                          else zero = 1'b1;
                default:  if (!after_stop) begin
                              if (ev_val) inc = 1'b1;
                              else        zero = 1'b1;
                          end
            endcase
        end
    end

    assign hit = inc && (cnt == need - CNT_W'(1));

    // Saturating run counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || zero) cnt <= '0;
        else if (inc && cnt < need) cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/uart_idle_rx.sv
// Top of the serial receiver: frame decode, idle detection, sleep and the
// two wakeup methods. Assumes a 16x tick and configuration held stable
// while a character is in flight.
module uart_idle_rx
    import uart_idle_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_in,
    input  logic              wake_addr,
    input  logic              idle_after_stop,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              nine_bit,
    input  logic              ten_bit,
    input  logic              sleep_req,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              par_err,
    output logic              idle_pulse,
    output logic              asleep
);
    localparam int IDX_W = $clog2(DATA_W + 2);
    localparam int CNT_W = $clog2(DATA_W + 4);

    logic              line_s, vote;
    logic [IDX_W-1:0]  n_data;
    logic [CNT_W-1:0]  need;
    logic              ev_valid, ev_val, fr_done, fr_perr, hit;
    ev_kind_t          ev_kind;
    logic [DATA_W-1:0] fr_data;
    logic              msb, idle_wake_mode, eff_after_stop, deliver, idle_fire, armed;

    assign n_data = ten_bit  ? IDX_W'(DATA_W)
                  : nine_bit ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
    assign need   = CNT_W'(n_data) + CNT_W'(par_en) + CNT_W'(2);

    rx_line_voter #(.SYNC_STAGES(SYNC_STAGES)) i_voter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in),
        .line_s(line_s), .vote(vote)
    );

    rx_framer #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_framer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_s(line_s), .vote(vote),
        .n_data(n_data), .par_en(par_en), .par_odd(par_odd),
        .ev_valid(ev_valid), .ev_val(ev_val), .ev_kind(ev_kind),
        .done(fr_done), .data(fr_data), .par_err(fr_perr)
    );

    assign idle_wake_mode = asleep && !wake_addr;
    assign eff_after_stop = idle_after_stop && !idle_wake_mode;

    rx_idle_count #(.CNT_W(CNT_W)) i_idle (
        .clk(clk), .rst_n(rst_n), .clr(sleep_req),
        .ev_valid(ev_valid), .ev_val(ev_val), .ev_kind(ev_kind),
        .after_stop(eff_after_stop), .need(need), .hit(hit)
    );

    assign msb       = |(fr_data & (DATA_W'(1) << (n_data - IDX_W'(1))));
    assign deliver   = fr_done && !sleep_req && (!asleep || (wake_addr && msb));
    assign idle_fire = hit && armed && !asleep;

    // Sleep state and wakeup.
    always_ff @(posedge clk) begin
        if (!rst_n)                       asleep <= 1'b0;
        else if (sleep_req)               asleep <= 1'b1;
        else if (idle_wake_mode && hit)   asleep <= 1'b0;
        else if (asleep && deliver)       asleep <= 1'b0;
    end

    // Character delivery register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
            par_err  <= 1'b0;
        end else begin
            rx_valid <= deliver;
            if (deliver) begin
                rx_data <= fr_data;
                par_err <= fr_perr;
            end
        end
    end

    // Idle pulse and its arm flag (one pulse per idle after traffic).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            idle_pulse <= 1'b0;
        end else begin
            idle_pulse <= idle_fire;
            if (deliver)        armed <= 1'b1;
            else if (idle_fire) armed <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_idle_rx_chk.sv
// Property checker for uart_idle_rx, attached by bind below.
module uart_idle_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_req,
    input logic       wake_addr,
    input logic       par_en,
    input logic       nine_bit,
    input logic       ten_bit,
    input logic [1:0] data_hi,
    input logic       rx_valid,
    input logic       par_err,
    input logic       idle_pulse,
    input logic       asleep
);
    a_r1_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    a_r1_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !$past(ten_bit) && !$past(nine_bit) |-> data_hi == 2'b00);
    a_r3_no_parity_err: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !$past(par_en) |-> !par_err);
    a_r7_idle_single: assert property (@(posedge clk) disable iff (!rst_n)
        idle_pulse |=> !idle_pulse);
    a_r7_idle_awake: assert property (@(posedge clk) disable iff (!rst_n)
        idle_pulse |-> !$past(asleep));
    a_r8_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> asleep);
    a_r8_no_delivery_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !asleep);
    a_r9_idle_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) && !$past(wake_addr) |-> !rx_valid);
    a_r10_addr_wake_delivers: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) && $past(wake_addr) |-> rx_valid);
endmodule

bind uart_idle_rx uart_idle_rx_chk i_chk (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_addr(wake_addr),
    .par_en(par_en), .nine_bit(nine_bit), .ten_bit(ten_bit),
    .data_hi(rx_data[DATA_W-1:DATA_W-2]), .rx_valid(rx_valid), .par_err(par_err),
    .idle_pulse(idle_pulse), .asleep(asleep)
);

// File: tb/test_uart_idle_rx.sv
// Directed bench for uart_idle_rx: one task per scenario.
module test_uart_idle_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       wake_addr = 1'b0, idle_after_stop = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic       nine_bit = 1'b0, ten_bit = 1'b0, sleep_req = 1'b0;
    logic [9:0] rx_data;
    logic       rx_valid, par_err, idle_pulse, asleep;

    int checks = 0, errors = 0, cyc = 0;
    int valid_cnt = 0, idle_cnt = 0, idle_cyc = 0, fs_cyc = 0;
    logic [9:0] got_data = '0;
    logic       got_perr = 1'b0;

    always #4 clk = ~clk;

    uart_idle_rx i_uart_idle_rx (
        .clk(clk), .rst_n(rst_n), .tick(1'b1), .rx_in(rx_in),
        .wake_addr(wake_addr), .idle_after_stop(idle_after_stop),
        .par_en(par_en), .par_odd(par_odd), .nine_bit(nine_bit), .ten_bit(ten_bit),
        .sleep_req(sleep_req), .rx_data(rx_data), .rx_valid(rx_valid),
        .par_err(par_err), .idle_pulse(idle_pulse), .asleep(asleep)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                valid_cnt <= valid_cnt + 1;
                got_data  <= rx_data;
                got_perr  <= par_err;
            end
            if (idle_pulse) begin
                idle_cnt <= idle_cnt + 1;
                idle_cyc <= cyc;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_win(string tag, int act, int lo, int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic drive_bit(logic v);
        rx_in = v;
        repeat (16) @(negedge clk);
    endtask

    // Sends one frame; glitch_at >= 0 inverts the line for one clock at that
    // offset from the start bit edge.
    task automatic send_frame(logic [9:0] d, int nb, logic pen, logic pbit, int glitch_at);
        logic [11:0] bits;
        int n;
        n = 0;
        bits = '0;
        bits[n++] = 1'b0;
        for (int i = 0; i < nb; i++) bits[n++] = d[i];
        if (pen) bits[n++] = pbit;
        bits[n++] = 1'b1;
        @(negedge clk);
        fs_cyc = cyc;
        for (int b = 0; b < n; b++) begin
            for (int k = 0; k < 16; k++) begin
                rx_in = ((b * 16 + k) == glitch_at) ? ~bits[b] : bits[b];
                @(negedge clk);
            end
        end
        rx_in = 1'b1;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sleep();
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset rx_valid", int'(rx_valid), 0);
        chk("R1 reset idle_pulse", int'(idle_pulse), 0);
        chk("R8 reset asleep", int'(asleep), 0);
        wait_cyc(400);
        chk("R7 no idle before any character", idle_cnt, 0);
    endtask

    task automatic t_formats();
        int v0;
        v0 = valid_cnt;
        send_frame(10'h0A5, 8, 1'b0, 1'b0, -1); wait_cyc(20);
        chk("R1 8-bit count", valid_cnt, v0 + 1);
        chk("R1 8-bit data", int'(got_data), 'h0A5);
        chk("R3 no parity flag", int'(got_perr), 0);
        wait_cyc(300);
        nine_bit = 1'b1;
        send_frame(10'h1A5, 9, 1'b0, 1'b0, -1); wait_cyc(20);
        chk("R1 9-bit data", int'(got_data), 'h1A5);
        wait_cyc(300);
        ten_bit = 1'b1;
        send_frame(10'h2C3, 10, 1'b0, 1'b0, -1); wait_cyc(20);
        chk("R1 10-bit wins over 9-bit", int'(got_data), 'h2C3);
        wait_cyc(300);
        nine_bit = 1'b0; ten_bit = 1'b0;
    endtask

    task automatic t_parity();
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(10'h007, 8, 1'b1, 1'b1, -1); wait_cyc(20);
        chk("R3 even parity good", int'(got_perr), 0);
        chk("R3 data with parity", int'(got_data), 'h007);
        wait_cyc(300);
        send_frame(10'h007, 8, 1'b1, 1'b0, -1); wait_cyc(20);
        chk("R3 even parity bad", int'(got_perr), 1);
        wait_cyc(300);
        par_odd = 1'b1;
        send_frame(10'h007, 8, 1'b1, 1'b0, -1); wait_cyc(20);
        chk("R3 odd parity good", int'(got_perr), 0);
        wait_cyc(300);
        send_frame(10'h006, 8, 1'b1, 1'b0, -1); wait_cyc(20);
        chk("R3 odd parity bad", int'(got_perr), 1);
        wait_cyc(300);
        par_en = 1'b0; par_odd = 1'b0;
    endtask

    task automatic t_noise();
        int v0;
        v0 = valid_cnt;
        @(negedge clk);
        rx_in = 1'b0; wait_cyc(4); rx_in = 1'b1;
        wait_cyc(400);
        chk("R2 short start rejected", valid_cnt, v0);
        send_frame(10'h000, 8, 1'b0, 1'b0, 16 * 2 + 8); wait_cyc(20);
        chk("R2 mid-bit glitch outvoted count", valid_cnt, v0 + 1);
        chk("R2 mid-bit glitch outvoted data", int'(got_data), 0);
        wait_cyc(400);
    endtask

    task automatic t_idle_after_start();
        int i0;
        idle_after_stop = 1'b0;
        i0 = idle_cnt;
        send_frame(10'h0FF, 8, 1'b0, 1'b0, -1); wait_cyc(300);
        chk("R4 one idle pulse", idle_cnt, i0 + 1);
        chk_win("R4 idle delay counts data ones", idle_cyc - fs_cyc, 169, 177);
        wait_cyc(400);
        chk("R7 single pulse per idle period", idle_cnt, i0 + 1);
    endtask

    task automatic t_idle_after_stop();
        int i0;
        idle_after_stop = 1'b1;
        i0 = idle_cnt;
        send_frame(10'h0FF, 8, 1'b0, 1'b0, -1); wait_cyc(420);
        chk("R5 idle pulse after stop", idle_cnt, i0 + 1);
        chk_win("R5 R6 delay L=10", idle_cyc - fs_cyc, 313, 321);
        par_en = 1'b1;
        send_frame(10'h0FF, 8, 1'b1, 1'b0, -1); wait_cyc(420);
        chk_win("R6 delay L=11", idle_cyc - fs_cyc, 345, 353);
        par_en = 1'b0; ten_bit = 1'b1;
        send_frame(10'h3FF, 10, 1'b0, 1'b0, -1); wait_cyc(420);
        chk_win("R6 delay L=12", idle_cyc - fs_cyc, 377, 385);
        chk("R7 one pulse per character", idle_cnt, i0 + 3);
        ten_bit = 1'b0;
    endtask

    task automatic t_wake_idle();
        int v0, i0;
        idle_after_stop = 1'b1; wake_addr = 1'b0;
        v0 = valid_cnt; i0 = idle_cnt;
        pulse_sleep();
        chk("R8 sleep request sets asleep", int'(asleep), 1);
        send_frame(10'h0FF, 8, 1'b0, 1'b0, -1);
        chk("R9 still asleep at frame end", int'(asleep), 1);
        wait_cyc(40);
        chk("R9 idle-type ignored, woken", int'(asleep), 0);
        chk("R8 character dropped while asleep", valid_cnt, v0);
        wait_cyc(400);
        chk("R7 no idle pulse from sleeping", idle_cnt, i0);
    endtask

    task automatic t_wake_addr();
        int v0;
        wake_addr = 1'b1;
        v0 = valid_cnt;
        pulse_sleep();
        send_frame(10'h012, 8, 1'b0, 1'b0, -1); wait_cyc(20);
        chk("R10 low mark discarded", valid_cnt, v0);
        chk("R10 low mark keeps asleep", int'(asleep), 1);
        wait_cyc(400);
        chk("R10 idle does not wake", int'(asleep), 1);
        send_frame(10'h095, 8, 1'b0, 1'b0, -1); wait_cyc(20);
        chk("R10 mark delivered", valid_cnt, v0 + 1);
        chk("R10 mark data", int'(got_data), 'h095);
        chk("R10 mark wakes", int'(asleep), 0);
        wake_addr = 1'b0;
        wait_cyc(400);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_formats();
        t_parity();
        t_noise();
        t_idle_after_start();
        t_idle_after_stop();
        t_wake_idle();
        t_wake_addr();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule